// File: doc/BRIEF.md
# Looping Sample Buffer with PWM Playback

This block keeps a stream of unsigned 8-bit mono audio samples in a circular two-port memory and plays the buffer back in an endless loop. A byte-valid strobe from an upstream receiver writes each arriving byte at the current write address, and that address then moves on by one. A separate sample-rate tick, 8 kHz in the intended system, fetches the sample at the current read address and advances that address. Both addresses return to zero after the last memory entry. A stream longer than the memory therefore overwrites the oldest samples.

The memory has one write-only port and one read-only port. The read port never writes. Read data is ready two clock cycles after the address is presented. A small delay line follows each tick through that latency. Only when the fetched word is valid does the pulse-width modulator take it as its new duty value. The modulator runs with a 256-cycle period and outputs a high level while its free-running 8-bit phase counter is below the held sample.

Top module: `sample_loop_player`

## Requirements
- R1: While `rst_n` is low at a rising edge, both address counters clear to 0 and the held duty value clears to 0. `pwm_out` then stays low until a tick loads a new sample. Contents written before the reset remain in memory.
- R2: Each cycle with `byte_valid` high stores `byte_data` at the write address, and the write address then advances by one. Consecutive bytes therefore land at adjacent addresses.
- R3: After a write at address DEPTH-1, the write address returns to 0. Further bytes overwrite the oldest entries.
- R4: Each cycle with `sample_tick` high fetches the sample at the current read address, and the read address then advances by one. The first tick after reset plays address 0.
- R5: After a fetch from address DEPTH-1, the read address returns to 0, so playback loops over the whole buffer.
- R6: A tick never changes memory contents, even when it arrives in the same cycle as a write to a different address.
- R7: The fetched sample becomes the duty value at the second rising edge after the edge that samples the tick. The duty value does not change at any other time.
- R8: Over any 256 consecutive cycles with a fixed duty value D (0 to 255), `pwm_out` is high in exactly D cycles. D = 0 gives a constantly low output, and D = 255 gives 255 high cycles out of 256.
- R9: Between ticks the duty value is held, so the same high count repeats in every 256-cycle period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_valid | input | 1 | Single-cycle strobe: store `byte_data` and advance the write address |
| byte_data | input | 8 | Unsigned audio sample to store |
| sample_tick | input | 1 | Single-cycle playback-rate tick: fetch the next sample and advance the read address |
| pwm_out | output | 1 | PWM audio output, high while the phase counter is below the held sample |

## Verification
The bench uses a depth of 8 and measures each played sample as a 256-cycle high count. A design with the wrong pipeline depth would play a neighbouring or stale entry. A comparison that is off by one would turn 0 into a glitch or 255 into a constant high. Ticks run past the last entry and bytes keep arriving after the buffer is full, so a counter that wraps one step early or late shows up as a shifted sequence. A tick that coincides with a write, and a reset in mid-playback, check that the read port leaves the memory alone and that reset clears the addresses while keeping the stored data.

// File: rtl/loop_player_pkg.sv
// Shared widths and types for the looping sample player.
package loop_player_pkg;
    localparam int SAMPLE_W = 8;   // bits per audio sample
    localparam int RD_LAT   = 2;   // memory read latency in clocks
    typedef logic [SAMPLE_W-1:0] sample_t;
endpackage

// File: rtl/wrap_counter.sv
// Address counter that steps on a single-cycle strobe and returns to zero
// after DEPTH-1. Assumes step is synchronous to clk; reset is synchronous
// and active low.
module wrap_counter #(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [AW-1:0] count
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // Advance on step, fold back to zero after the final entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (step)
            count <= (count == LAST) ? '0 : count + AW'(1);
    end

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (step && count == LAST) |=> (count == '0));                    // R3 R5
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && count != LAST) |=> (count == $past(count) + AW'(1))); // R2 R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(count));                                     // R2 R4
    AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LAST);                                                // R3 R5
endmodule

// File: rtl/sample_ram.sv
// Two-port sample memory: port B writes only, port A reads only, with a
// registered address and a registered output (two-cycle read latency).
// Read-before-write when both ports touch one address in the same cycle.
// Contents are not reset.
module sample_ram
    import loop_player_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output sample_t       rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  sample_t       wr_data
);
    sample_t       mem [DEPTH];
    logic [AW-1:0] rd_addr_q;

    // Write port: store the byte when enabled.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    // Read port: register the address, then the data word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr_q <= '0;
            rd_data   <= '0;
        end else begin
            rd_addr_q <= rd_addr;
            rd_data   <= mem[rd_addr_q];
        end
    end

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < DEPTH));                            // R2
endmodule

// File: rtl/pwm_gen.sv
// PWM generator with a free-running phase counter of SAMPLE_W bits.
// The output is high while the phase is below the held duty value. A new
// duty is taken only on load. Reset clears the duty so the output is low.
module pwm_gen
    import loop_player_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load,
    input  sample_t sample,
    output logic    pwm_out
);
    sample_t phase;
    sample_t duty_q;

    // Phase counter runs through the full 2**SAMPLE_W period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else
            phase <= phase + sample_t'(1);
    end

    // Hold the duty value between loads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            duty_q <= '0;
        else if (load)
            duty_q <= sample;
    end

    // Compare phase against duty.
    always_comb pwm_out = (phase < duty_q);

    AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(duty_q));                                    // R9
    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q == '0) |-> !pwm_out);                                  // R8
    AST_FULL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q == '1 && phase == '1) |-> !pwm_out);                   // R8
endmodule

// File: rtl/sample_loop_player.sv
// Looping sample buffer: writes follow byte_valid, reads follow sample_tick,
// and both addresses wrap at DEPTH. A delay line as long as the memory read
// latency tells the PWM when the fetched word is valid.
// Assumes byte_valid and sample_tick are single-cycle strobes.
module sample_loop_player
    import loop_player_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                byte_valid,
    input  logic [SAMPLE_W-1:0] byte_data,
    input  logic                sample_tick,
    output logic                pwm_out
);
    logic [AW-1:0]     wr_addr;
    logic [AW-1:0]     rd_addr;
    sample_t           rd_data;
    logic [RD_LAT-1:0] fetch_pipe;
    logic              load;

    wrap_counter #(.DEPTH(DEPTH), .AW(AW)) i_wr_cnt (
        .clk(clk), .rst_n(rst_n), .step(byte_valid), .count(wr_addr)
    );

    wrap_counter #(.DEPTH(DEPTH), .AW(AW)) i_rd_cnt (
        .clk(clk), .rst_n(rst_n), .step(sample_tick), .count(rd_addr)
    );

    sample_ram #(.DEPTH(DEPTH), .AW(AW)) i_ram (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(byte_valid), .wr_addr(wr_addr), .wr_data(byte_data)
    );

    // Track each tick through the memory read latency.
    generate
        if (RD_LAT == 1) begin : g_lat1
            always_ff @(posedge clk) begin
                if (!rst_n) fetch_pipe <= '0;
                else        fetch_pipe <= sample_tick;
            end
        end else begin : g_latn
            always_ff @(posedge clk) begin
                if (!rst_n) fetch_pipe <= '0;
                else        fetch_pipe <= {fetch_pipe[RD_LAT-2:0], sample_tick};
            end
        end
    endgenerate

    assign load = fetch_pipe[RD_LAT-1];

    pwm_gen i_pwm (
        .clk(clk), .rst_n(rst_n), .load(load), .sample(rd_data), .pwm_out(pwm_out)
    );

    AST_LOAD_AFTER_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> $past(sample_tick, RD_LAT));                          // R7
    AST_TICK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |=> ##1 load);                                     // R7
endmodule

// File: tb/test_sample_loop_player.sv
`timescale 1ns/1ps
module test_sample_loop_player;
    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       sample_tick = 1'b0;
    logic       pwm_out;

    int checks = 0;
    int errors = 0;
    int model [DEPTH];
    int wp = 0;
    int rp = 0;

    always #10 clk = ~clk;   // 50 MHz

    sample_loop_player #(.DEPTH(DEPTH)) i_sample_loop_player (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid),
        .byte_data(byte_data), .sample_tick(sample_tick), .pwm_out(pwm_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic count_high(output int n);
        n = 0;
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            if (pwm_out) n++;
        end
    endtask

    task automatic put_byte(input int v);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = 8'(v);
        @(negedge clk);
        byte_valid = 1'b0;
        model[wp] = v;
        wp = (wp + 1) % DEPTH;
    endtask

    // Tick, wait past the latency, then measure one full PWM period.
    task automatic tick_check(input string tag);
        int n;
        int exp;
        exp = model[rp];
        rp = (rp + 1) % DEPTH;
        @(negedge clk);
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
        repeat (2) @(negedge clk);
        count_high(n);
        check(tag, n, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        wp = 0;
        rp = 0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int vals [8] = '{0, 255, 1, 128, 37, 200, 99, 254};
        do_reset();
        count_high(n);
        check("R1 low after reset", n, 0);

        // R2: fill the buffer with known bytes.
        for (int i = 0; i < DEPTH; i++) put_byte(vals[i]);
        // R4 R8: play every entry, including 0 and 255.
        for (int i = 0; i < DEPTH; i++) tick_check("R4 R8 playback");
        // R5: next tick wraps back to address 0.
        tick_check("R5 read wrap");
        // R9: duty persists over another period without a tick.
        count_high(n);
        check("R9 held duty", n, model[(rp + DEPTH - 1) % DEPTH]);

        // R3: three more bytes overwrite addresses 0..2.
        put_byte(11);
        put_byte(22);
        put_byte(33);
        for (int i = 0; i < DEPTH; i++) tick_check("R3 overwrite loop");

        // R6: tick together with a write to another address.
        begin
            int exp;
            exp = model[rp];
            @(negedge clk);
            sample_tick = 1'b1;
            byte_valid  = 1'b1;
            byte_data   = 8'd77;
            @(negedge clk);
            sample_tick = 1'b0;
            byte_valid  = 1'b0;
            model[wp] = 77;
            wp = (wp + 1) % DEPTH;
            rp = (rp + 1) % DEPTH;
            repeat (2) @(negedge clk);
            count_high(n);
            check("R6 R7 tick with write", n, exp);
        end
        for (int i = 0; i < DEPTH; i++) tick_check("R6 R2 contents after ticks");

        // R1: mid-run reset clears addresses and duty, keeps memory.
        do_reset();
        count_high(n);
        check("R1 low after mid reset", n, 0);
        tick_check("R1 read addr zero");
        put_byte(5);
        for (int i = 0; i < DEPTH; i++) tick_check("R1 R2 write addr zero");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule